// File: doc/BRIEF.md
# Tachometer Timer Register Bank

This block is the register bank behind a two-channel fan tachometer timer. It sits between a simple bus port (valid, write, size, address, data) and the counting and capture datapath. It decodes fifteen halfword-spaced registers and allows exactly one access width per register. An access of the wrong width, at an odd address or to an unmapped offset is refused and has no side effect.

The bank holds configuration, interrupt enables and interrupt flags, and it drives one level interrupt. The datapath is outside this block. It raises flags through set strobes and loads counter and capture values through data ports. Every accepted write to a configuration register produces a one-cycle strobe, so the datapath can pick up new settings. A synchronous reset clears the configuration, enable and flag registers. The counter and capture registers keep their contents through reset.

Top module: `tach_regbank`

## Requirements
- R1: With `bus_size` 1 meaning a 16-bit access and 0 an 8-bit access, offsets 0x00 (counter A), 0x02 (capture A), 0x04 (capture B), 0x06 (counter B), 0x14 (compare A) and 0x16 (compare B) accept only 16-bit accesses. Offsets 0x08 (prescaler), 0x0A (clock control), 0x0C (mode), 0x0E (flags), 0x10 (flag clear), 0x12 (enable), 0x18 (compare control), 0x1A (input select A) and 0x1C (input select B) accept only 8-bit accesses. An 8-bit write uses `bus_wdata[7:0]`.
- R2: An access of the wrong width, at an odd address, or at offset 0x1E or above is refused. It changes no register and raises no strobe. `bus_err` is high for exactly the cycle after the request and `bus_rdata` is zero in that cycle.
- R3: An accepted read presents the register value on `bus_rdata` in the cycle after the request, with 8-bit registers zero-extended. `bus_rdata` is zero in every cycle that does not follow an accepted read.
- R4: Writing offset 0x10 clears each flag whose written bit is 1 and leaves the other flags unchanged. Reading 0x10 returns zero.
- R5: Flag bits are: bit0 capture A, bit1 capture B, bit2 underflow A, bit3 underflow B, bit4 compare hit A, bit5 compare hit B. `set_flag` uses the same positions. A set wins over a clear of the same bit in the same cycle. A bus write to 0x0E is accepted but does not change the flags.
- R6: `irq` is registered. It is high exactly when some flag is set whose enable bit (offset 0x12, same positions) is also set, starting in the same cycle the flag becomes readable.
- R7: A synchronous reset zeroes the registers from 0x08 through 0x1C and forces `irq` low. The registers at 0x00 to 0x06 keep their values.
- R8: `dp_cnt_we[c]` loads counter c and `dp_cap_we[c]` loads capture c (c=0 is channel A) from slice c of the matching data port. A datapath load takes priority over a bus write to the same register in the same cycle.
- R9: `cfg_changed` is high for one cycle after each accepted write to the prescaler, clock control, mode, compare A, compare B, compare control or either input select. It stays low for writes to any other register and for refused accesses.
- R10: The `cfg_*` outputs show the current contents of their configuration registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 write, 0 read |
| bus_size | input | 1 | 1 = 16-bit, 0 = 8-bit |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after request |
| bus_err | output | 1 | Refused-access pulse |
| set_flag | input | 6 | Flag set strobes from the datapath |
| dp_cnt_we | input | 2 | Counter load strobes per channel |
| dp_cnt_data | input | 2*DATA_W | Counter load values, channel A in low slice |
| dp_cap_we | input | 2 | Capture load strobes per channel |
| dp_cap_data | input | 2*DATA_W | Capture load values, channel A in low slice |
| irq | output | 1 | Level interrupt |
| cfg_changed | output | 1 | Configuration write strobe |
| cfg_prescale | output | 8 | Prescaler |
| cfg_clk_ctl | output | 8 | Clock control |
| cfg_mode | output | 8 | Mode control |
| cfg_cmp_ctl | output | 8 | Compare control |
| cfg_sel_a | output | 8 | Input select A |
| cfg_sel_b | output | 8 | Input select B |
| cfg_cmp_a | output | DATA_W | Compare value A |
| cfg_cmp_b | output | DATA_W | Compare value B |

## Verification
The bound checker watches a set of invariants on every cycle:
- `irq` always agrees with the flag and enable state.
- `irq` is low after reset.
- A strobed flag is always visible on the next cycle.
- Odd-address requests always draw an error, and an error cycle always carries zero read data.
- `cfg_changed` only follows a write.

Other behaviour depends on the register map, and only the bench's scenarios can show it:
- Per-offset width legality.
- Write-one-to-clear masking.
- The ignored write to the flag register.
- The set-over-clear race.
- Datapath priority over the bus.
- Counters and captures surviving a reset that clears everything else.

// File: rtl/tach_rb_pkg.sv
package tach_rb_pkg;
  localparam int NCH     = 2;
  localparam int NFLAG   = 3 * NCH;
  localparam int REG_N   = 15;
  localparam int IDX_W   = 4;
  localparam int BYTE_W  = 8;
  localparam int CFG_BYTES = 6;
  localparam int CFG_WIDE  = 2;

  typedef enum logic [IDX_W-1:0] {
    RI_CNT_A  = 4'd0,  RI_CAP_A  = 4'd1,  RI_CAP_B  = 4'd2,
    RI_CNT_B  = 4'd3,  RI_PRESC  = 4'd4,  RI_CLKCTL = 4'd5,
    RI_MODE   = 4'd6,  RI_FLAGS  = 4'd7,  RI_CLR    = 4'd8,
    RI_IEN    = 4'd9,  RI_CMP_A  = 4'd10, RI_CMP_B  = 4'd11,
    RI_CMPCTL = 4'd12, RI_SEL_A  = 4'd13, RI_SEL_B  = 4'd14,
    RI_NONE   = 4'd15
  } reg_idx_e;

  // bit per register index: 1 = 16-bit access only
  localparam logic [2**IDX_W-1:0] WIDE_MASK = 16'h0C0F;
  // bit per register index: writes raise the config strobe
  localparam logic [2**IDX_W-1:0] CFG_MASK  = 16'h7C70;

  localparam int BYTE_IDX [CFG_BYTES] = '{4, 5, 6, 12, 13, 14};
  localparam int WIDE_IDX [CFG_WIDE]  = '{10, 11};
  localparam int CNT_IDX  [NCH]       = '{0, 3};
  localparam int CAP_IDX  [NCH]       = '{1, 2};
endpackage

// File: rtl/tach_rb_decode.sv
module tach_rb_decode import tach_rb_pkg::*; #(
  parameter int ADDR_W = 5
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              acc_ok,
  output logic              acc_bad,
  output logic              rd_en,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [REG_N-1:0]  wr_en,
  output logic              cfg_wr
);
  localparam int SLOT_W = ADDR_W - 1;

  logic [SLOT_W-1:0] slot;
  logic [IDX_W-1:0]  idx;
  logic              mapped;
  logic              size_ok;

  assign slot    = bus_addr[ADDR_W-1:1];
  assign idx     = slot[IDX_W-1:0];
  assign mapped  = !bus_addr[0] && (32'(slot) < REG_N);
  assign size_ok = (bus_size == WIDE_MASK[idx]);
  assign acc_ok  = bus_valid && mapped && size_ok;
  assign acc_bad = bus_valid && !(mapped && size_ok);
  assign rd_en   = acc_ok && !bus_write;
  assign rd_idx  = idx;

  for (genvar g = 0; g < REG_N; g++) begin : g_we
    assign wr_en[g] = acc_ok && bus_write && (idx == IDX_W'(g));
  end

  assign cfg_wr = |(wr_en & CFG_MASK[REG_N-1:0]);
endmodule

// File: rtl/tach_rb_flags.sv
module tach_rb_flags #(
  parameter int NFLAG = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] set_i,
  input  logic             clr_we,
  input  logic [NFLAG-1:0] clr_data,
  input  logic             ien_we,
  input  logic [NFLAG-1:0] ien_data,
  output logic [NFLAG-1:0] flag_o,
  output logic [NFLAG-1:0] ien_o,
  output logic             irq_o
);
  logic [NFLAG-1:0] flag_q, ien_q, flag_d, ien_d, clr_mask;

  assign clr_mask = clr_we ? clr_data : '0;
  assign flag_d   = (flag_q & ~clr_mask) | set_i;
  assign ien_d    = ien_we ? ien_data : ien_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      ien_q  <= '0;
      irq_o  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      ien_q  <= ien_d;
      irq_o  <= |(flag_d & ien_d);
    end
  end

  assign flag_o = flag_q;
  assign ien_o  = ien_q;
endmodule

// File: rtl/tach_rb_cfg.sv
module tach_rb_cfg import tach_rb_pkg::*; #(
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [REG_N-1:0]              wr_en,
  input  logic [DATA_W-1:0]             wdata,
  output logic [CFG_BYTES*BYTE_W-1:0]   byte_o,
  output logic [CFG_WIDE*DATA_W-1:0]    wide_o
);
  for (genvar b = 0; b < CFG_BYTES; b++) begin : g_byte
    logic [BYTE_W-1:0] r;
    always_ff @(posedge clk) begin
      if (rst)                 r <= '0;
      else if (wr_en[BYTE_IDX[b]]) r <= wdata[BYTE_W-1:0];
    end
    assign byte_o[b*BYTE_W +: BYTE_W] = r;
  end

  for (genvar w = 0; w < CFG_WIDE; w++) begin : g_wide
    logic [DATA_W-1:0] r;
    always_ff @(posedge clk) begin
      if (rst)                 r <= '0;
      else if (wr_en[WIDE_IDX[w]]) r <= wdata;
    end
    assign wide_o[w*DATA_W +: DATA_W] = r;
  end
endmodule

// File: rtl/tach_regbank.sv
module tach_regbank import tach_rb_pkg::*; #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_valid,
  input  logic                  bus_write,
  input  logic                  bus_size,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic                  bus_err,
  input  logic [NFLAG-1:0]      set_flag,
  input  logic [NCH-1:0]        dp_cnt_we,
  input  logic [NCH*DATA_W-1:0] dp_cnt_data,
  input  logic [NCH-1:0]        dp_cap_we,
  input  logic [NCH*DATA_W-1:0] dp_cap_data,
  output logic                  irq,
  output logic                  cfg_changed,
  output logic [BYTE_W-1:0]     cfg_prescale,
  output logic [BYTE_W-1:0]     cfg_clk_ctl,
  output logic [BYTE_W-1:0]     cfg_mode,
  output logic [BYTE_W-1:0]     cfg_cmp_ctl,
  output logic [BYTE_W-1:0]     cfg_sel_a,
  output logic [BYTE_W-1:0]     cfg_sel_b,
  output logic [DATA_W-1:0]     cfg_cmp_a,
  output logic [DATA_W-1:0]     cfg_cmp_b
);
  logic                 acc_ok, acc_bad, rd_en, cfg_wr;
  logic [IDX_W-1:0]     rd_idx;
  logic [REG_N-1:0]     wr_en;
  logic [NFLAG-1:0]     flag_q, ien_q;
  logic [CFG_BYTES*BYTE_W-1:0] cfg_bytes;
  logic [CFG_WIDE*DATA_W-1:0]  cfg_wide;
  logic [DATA_W-1:0]    cnt_w [NCH];
  logic [DATA_W-1:0]    cap_w [NCH];
  logic [DATA_W-1:0]    rd_val;

  tach_rb_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_size(bus_size),
    .bus_addr(bus_addr), .acc_ok(acc_ok), .acc_bad(acc_bad),
    .rd_en(rd_en), .rd_idx(rd_idx), .wr_en(wr_en), .cfg_wr(cfg_wr)
  );

  tach_rb_flags #(.NFLAG(NFLAG)) u_flags (
    .clk(clk), .rst(rst), .set_i(set_flag),
    .clr_we(wr_en[RI_CLR]), .clr_data(bus_wdata[NFLAG-1:0]),
    .ien_we(wr_en[RI_IEN]), .ien_data(bus_wdata[NFLAG-1:0]),
    .flag_o(flag_q), .ien_o(ien_q), .irq_o(irq)
  );

  tach_rb_cfg #(.DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(bus_wdata),
    .byte_o(cfg_bytes), .wide_o(cfg_wide)
  );

  // counter and capture registers: untouched by reset
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DATA_W-1:0] cnt_r, cap_r;
    always_ff @(posedge clk) begin
      if (dp_cnt_we[c])            cnt_r <= dp_cnt_data[c*DATA_W +: DATA_W];
      else if (wr_en[CNT_IDX[c]])  cnt_r <= bus_wdata;
      if (dp_cap_we[c])            cap_r <= dp_cap_data[c*DATA_W +: DATA_W];
      else if (wr_en[CAP_IDX[c]])  cap_r <= bus_wdata;
    end
    assign cnt_w[c] = cnt_r;
    assign cap_w[c] = cap_r;
  end

  assign cfg_prescale = cfg_bytes[0*BYTE_W +: BYTE_W];
  assign cfg_clk_ctl  = cfg_bytes[1*BYTE_W +: BYTE_W];
  assign cfg_mode     = cfg_bytes[2*BYTE_W +: BYTE_W];
  assign cfg_cmp_ctl  = cfg_bytes[3*BYTE_W +: BYTE_W];
  assign cfg_sel_a    = cfg_bytes[4*BYTE_W +: BYTE_W];
  assign cfg_sel_b    = cfg_bytes[5*BYTE_W +: BYTE_W];
  assign cfg_cmp_a    = cfg_wide[0 +: DATA_W];
  assign cfg_cmp_b    = cfg_wide[DATA_W +: DATA_W];

  always_comb begin
    rd_val = '0;
    case (rd_idx)
      RI_CNT_A:  rd_val = cnt_w[0];
      RI_CAP_A:  rd_val = cap_w[0];
      RI_CAP_B:  rd_val = cap_w[1];
      RI_CNT_B:  rd_val = cnt_w[1];
      RI_PRESC:  rd_val = {{(DATA_W-BYTE_W){1'b0}}, cfg_prescale};
      RI_CLKCTL: rd_val = {{(DATA_W-BYTE_W){1'b0}}, cfg_clk_ctl};
      RI_MODE:   rd_val = {{(DATA_W-BYTE_W){1'b0}}, cfg_mode};
      RI_FLAGS:  rd_val = {{(DATA_W-NFLAG){1'b0}}, flag_q};
      RI_IEN:    rd_val = {{(DATA_W-NFLAG){1'b0}}, ien_q};
      RI_CMP_A:  rd_val = cfg_cmp_a;
      RI_CMP_B:  rd_val = cfg_cmp_b;
      RI_CMPCTL: rd_val = {{(DATA_W-BYTE_W){1'b0}}, cfg_cmp_ctl};
      RI_SEL_A:  rd_val = {{(DATA_W-BYTE_W){1'b0}}, cfg_sel_a};
      RI_SEL_B:  rd_val = {{(DATA_W-BYTE_W){1'b0}}, cfg_sel_b};
      default:   rd_val = '0;   // clear register and unmapped read as zero
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata   <= '0;
      bus_err     <= 1'b0;
      cfg_changed <= 1'b0;
    end else begin
      bus_rdata   <= rd_en ? rd_val : '0;
      bus_err     <= acc_bad;
      cfg_changed <= cfg_wr;
    end
  end
endmodule

// File: rtl/tach_regbank_chk.sv
module tach_regbank_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int NFLAG  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_err,
  input logic [NFLAG-1:0]  set_flag,
  input logic [NFLAG-1:0]  flag_q,
  input logic [NFLAG-1:0]  ien_q,
  input logic              irq,
  input logic              cfg_changed
);
  p_odd_addr_refused_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(bus_valid) && $past(bus_addr[0]) |-> bus_err);

  p_err_zero_data_r2: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> bus_rdata == '0);

  p_no_idle_err_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_valid) |-> !bus_err);

  p_irq_tracks_flags_r6: assert property (@(posedge clk) disable iff (rst)
    irq == |(flag_q & ien_q));

  p_irq_low_after_reset_r7: assert property (@(posedge clk)
    $past(rst) |-> !irq);

  p_set_lands_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(|set_flag) |-> ((flag_q & $past(set_flag)) == $past(set_flag)));

  p_cfg_strobe_on_write_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_changed |-> ($past(bus_valid) && $past(bus_write) && !bus_err));
endmodule

bind tach_regbank tach_regbank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NFLAG(tach_rb_pkg::NFLAG)) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_err(bus_err),
  .set_flag(set_flag), .flag_q(flag_q), .ien_q(ien_q), .irq(irq),
  .cfg_changed(cfg_changed)
);

// File: tb/sim_tach_regbank.sv
module sim_tach_regbank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0, bus_size = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_err, irq, cfg_changed;
  logic [5:0]  set_flag = '0;
  logic [1:0]  dp_cnt_we = '0, dp_cap_we = '0;
  logic [31:0] dp_cnt_data = '0, dp_cap_data = '0;
  logic [7:0]  cfg_prescale, cfg_clk_ctl, cfg_mode, cfg_cmp_ctl, cfg_sel_a, cfg_sel_b;
  logic [15:0] cfg_cmp_a, cfg_cmp_b;

  int chk_cnt = 0;
  int err_cnt = 0;
  bit done = 0;
  bit sent = 0;

  logic [15:0] exp_rd [$];
  logic        exp_er [$];
  string       exp_tg [$];

  always #5 clk = ~clk;

  tach_regbank u0 (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .set_flag(set_flag),
    .dp_cnt_we(dp_cnt_we), .dp_cnt_data(dp_cnt_data),
    .dp_cap_we(dp_cap_we), .dp_cap_data(dp_cap_data),
    .irq(irq), .cfg_changed(cfg_changed),
    .cfg_prescale(cfg_prescale), .cfg_clk_ctl(cfg_clk_ctl), .cfg_mode(cfg_mode),
    .cfg_cmp_ctl(cfg_cmp_ctl), .cfg_sel_a(cfg_sel_a), .cfg_sel_b(cfg_sel_b),
    .cfg_cmp_a(cfg_cmp_a), .cfg_cmp_b(cfg_cmp_b)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    chk_cnt++;
    if (act !== exp) begin
      err_cnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one bus access, expectation pushed to the scoreboard
  task automatic access(input logic w, input logic sz, input logic [4:0] a,
                        input logic [15:0] d, input logic [15:0] erd,
                        input logic eerr, input string tag);
    bus_valid = 1'b1; bus_write = w; bus_size = sz; bus_addr = a; bus_wdata = d;
    exp_rd.push_back(erd); exp_er.push_back(eerr); exp_tg.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    set_flag = '0; dp_cnt_we = '0; dp_cap_we = '0;
  endtask

  task automatic wr(input logic sz, input logic [4:0] a, input logic [15:0] d, input string tag);
    access(1'b1, sz, a, d, 16'h0, 1'b0, tag);
  endtask

  task automatic rd(input logic sz, input logic [4:0] a, input logic [15:0] e, input string tag);
    access(1'b0, sz, a, 16'h0, e, 1'b0, tag);
  endtask

  // monitor: compares each result in the cycle after its request
  always @(posedge clk) sent <= bus_valid;
  always @(negedge clk) begin
    if (sent) begin
      if (exp_rd.size() == 0) begin
        chk_cnt++; err_cnt++;
        $display("FAIL R3 unexpected result actual=%h expected=none", bus_rdata);
      end else begin
        check({exp_tg[0], " rdata"}, bus_rdata, exp_rd.pop_front());
        check({exp_tg[0], " err"}, {15'b0, bus_err}, {15'b0, exp_er.pop_front()});
        void'(exp_tg.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      err_cnt++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", chk_cnt, err_cnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7 irq in reset", {15'b0, irq}, 16'h0);
    check("R2 err in reset", {15'b0, bus_err}, 16'h0);
    check("R9 strobe in reset", {15'b0, cfg_changed}, 16'h0);
    rst = 1'b0;
    @(negedge clk);

    // R1 16-bit registers
    wr(1'b1, 5'h00, 16'h1234, "R1 cnt A wr");
    check("R9 no strobe on counter", {15'b0, cfg_changed}, 16'h0);
    wr(1'b1, 5'h06, 16'hBEEF, "R1 cnt B wr");
    wr(1'b1, 5'h02, 16'h5555, "R1 cap A wr");
    wr(1'b1, 5'h04, 16'hAAAA, "R1 cap B wr");
    rd(1'b1, 5'h00, 16'h1234, "R3 cnt A rd");
    rd(1'b1, 5'h06, 16'hBEEF, "R3 cnt B rd");
    rd(1'b1, 5'h04, 16'hAAAA, "R3 cap B rd");

    // R9/R10 byte config write
    wr(1'b0, 5'h08, 16'hFFA5, "R1 presc wr");
    check("R9 strobe after presc", {15'b0, cfg_changed}, 16'h1);
    check("R10 prescale out", {8'h0, cfg_prescale}, 16'h00A5);
    @(negedge clk);
    check("R9 strobe one cycle", {15'b0, cfg_changed}, 16'h0);
    rd(1'b0, 5'h08, 16'h00A5, "R3 presc zero-ext");

    // R2 refused accesses
    access(1'b1, 1'b1, 5'h08, 16'h0000, 16'h0, 1'b1, "R2 wide write to byte reg");
    check("R2 no strobe on refused", {15'b0, cfg_changed}, 16'h0);
    rd(1'b0, 5'h08, 16'h00A5, "R2 presc untouched");
    access(1'b0, 1'b0, 5'h00, 16'h0, 16'h0, 1'b1, "R2 byte read of counter");
    access(1'b0, 1'b0, 5'h09, 16'h0, 16'h0, 1'b1, "R2 odd address");
    access(1'b0, 1'b1, 5'h1E, 16'h0, 16'h0, 1'b1, "R2 unmapped 0x1E");
    access(1'b1, 1'b1, 5'h01, 16'hFFFF, 16'h0, 1'b1, "R2 odd wide write");
    rd(1'b1, 5'h00, 16'h1234, "R2 counter untouched");

    // R6 interrupt gating
    wr(1'b0, 5'h12, 16'h0001, "R6 enable wr");
    check("R9 no strobe on enable", {15'b0, cfg_changed}, 16'h0);
    set_flag = 6'h02;
    @(negedge clk); set_flag = '0;
    check("R6 irq off for disabled flag", {15'b0, irq}, 16'h0);
    rd(1'b0, 5'h0E, 16'h0002, "R5 capture B flag bit1");
    set_flag = 6'h01;
    @(negedge clk); set_flag = '0;
    check("R6 irq on for enabled flag", {15'b0, irq}, 16'h1);

    // R4 write-one-to-clear
    wr(1'b0, 5'h10, 16'h0001, "R4 clear bit0");
    check("R6 irq drops after clear", {15'b0, irq}, 16'h0);
    rd(1'b0, 5'h10, 16'h0000, "R4 clear reads zero");
    rd(1'b0, 5'h0E, 16'h0002, "R4 other flag kept");

    // R5 ignored write, set beats clear
    wr(1'b0, 5'h0E, 16'h003F, "R5 flag write");
    rd(1'b0, 5'h0E, 16'h0002, "R5 flag write ignored");
    set_flag = 6'h04;
    wr(1'b0, 5'h10, 16'h0004, "R5 clear same bit as set");
    rd(1'b0, 5'h0E, 16'h0006, "R5 set wins");

    // R8 datapath priority
    dp_cnt_we = 2'b01; dp_cnt_data = {16'h0000, 16'h0F0F};
    wr(1'b1, 5'h00, 16'h1111, "R8 bus write loses");
    rd(1'b1, 5'h00, 16'h0F0F, "R8 datapath counter A");
    dp_cap_we = 2'b10; dp_cap_data = {16'h7777, 16'h0000};
    @(negedge clk); dp_cap_we = '0;
    rd(1'b1, 5'h04, 16'h7777, "R8 datapath capture B");
    rd(1'b1, 5'h02, 16'h5555, "R8 capture A unchanged");

    // R10 wide config and selects
    wr(1'b1, 5'h14, 16'h4321, "R1 compare A wr");
    check("R9 strobe after compare", {15'b0, cfg_changed}, 16'h1);
    check("R10 compare A out", cfg_cmp_a, 16'h4321);
    wr(1'b0, 5'h1C, 16'h0001, "R1 select B wr");
    check("R10 select B out", {8'h0, cfg_sel_b}, 16'h0001);

    // R7 partial reset
    wr(1'b0, 5'h12, 16'h003F, "R6 enable all");
    check("R6 irq with pending flags", {15'b0, irq}, 16'h1);
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R7 irq low in reset", {15'b0, irq}, 16'h0);
    check("R7 prescale cleared", {8'h0, cfg_prescale}, 16'h0);
    check("R7 compare A cleared", cfg_cmp_a, 16'h0);
    rst = 1'b0;
    @(negedge clk);
    rd(1'b0, 5'h0E, 16'h0000, "R7 flags cleared");
    rd(1'b0, 5'h12, 16'h0000, "R7 enable cleared");
    rd(1'b0, 5'h1C, 16'h0000, "R7 select B cleared");
    rd(1'b1, 5'h00, 16'h0F0F, "R7 counter A kept");
    rd(1'b1, 5'h06, 16'hBEEF, "R7 counter B kept");
    rd(1'b1, 5'h04, 16'h7777, "R7 capture B kept");
    @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", chk_cnt, err_cnt);
    $finish;
  end
endmodule